// File: doc/BRIEF.md
# Debug register save-restore sequencer

This block gives software a single 32-bit window through which the contents of 22 debug registers can be saved before power is removed and loaded back afterwards. Software first writes a fixed 32-bit key to a separate lock-access location. This engages the lock and moves the internal pointer to the start of the sequence. The first read of the window then returns how many registers follow. After that, each access moves exactly one register, in a fixed order. Reads stream the registers out (save) and writes load them back (restore).

The first access after the length read sets the direction for the rest of the sequence. A restore loads only the bits software may write. Read-only status bits keep tracking live state, except for four status bits in the debug status/control register, which a restore does load. Every case the protocol leaves undefined is handled the same way. The access is ignored, a read returns zero, and a sticky error flag is raised. A side port lets the environment drive the read-only status bits of any register. Every bus access completes in the cycle it is issued and never stalls.

Register order (sequence index in brackets): watchpoint controls 1, 0 [0,1]; watchpoint values 1, 0 [2,3]; breakpoint controls 5 down to 0 [4..9]; breakpoint values 5 down to 0 [10..15]; transmit data [16]; debug status/control [17]; receive data [18]; cache control [19]; vector catch [20]; fault address [21].

Top module: `dsr_save_restore`

## Requirements
- R1: After reset the lock is clear, the error flag is low, the done flag is low, register 17 holds 0x00000002 and every other register holds 0.
- R2: A write of 0xC5ACCE55 with bus_sel=1 sets locked, clears seq_err and returns the pointer to the start of the sequence, from any state.
- R3: The first read of the window (bus_sel=0) after the key returns 22 (0x00000016) in the same cycle.
- R4: Each read after the length read returns the registers in sequence index order 0 to 21, one per access.
- R5: A restore write to index i replaces only the bits set in that register's restore mask: 0x1F1FFFFF for indices 0-1, 0xFFFFFFFC for 2-3 and 10-15, 0x0077FFFF for 4-9, 0xFFFFFFFF for 16 and 18, 0x6C60C0FC for 17, 0x00000007 for 19, 0x000000DF for 20, 0xFFFFFFFE for 21.
- R6: A status side-port write replaces the bits outside the writable mask, which equals the restore mask except that for index 17 it is 0x0060C0FC. A restore leaves those bits unchanged, apart from index 17 bits 30:29 and 27:26.
- R7: The first access after the length read fixes the direction. An access in the other direction, or a read and a write in the same cycle, is ignored, reads 0 and sets seq_err. The pointer does not move.
- R8: A window write issued before the length read is ignored and sets seq_err. The next read still returns the length.
- R9: After the 22nd transfer seq_done is high. Any further window access is ignored, reads 0 and sets seq_err.
- R10: A key write in the middle of a sequence restarts it from the length read. Registers restored before the restart keep their new values.
- R11: A lock-access write of any value other than the key clears locked and seq_done. Window accesses while unlocked are ignored, read 0 and set seq_err. seq_err stays high until the next key write.
- R12: A read with bus_sel=1 returns locked in bit 0 and zeros in all other bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | 0 selects the save/restore window, 1 the lock-access location |
| bus_rd | input | 1 | Read strobe, one access per cycle |
| bus_wr | input | 1 | Write strobe, one access per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the read strobe |
| stat_we | input | 1 | Status side-port write enable |
| stat_idx | input | 5 | Sequence index targeted by the status write |
| stat_data | input | 32 | New values for the read-only bits |
| locked | output | 1 | Lock engaged |
| seq_err | output | 1 | Sticky error for ignored accesses |
| seq_done | output | 1 | All 22 transfers completed |

## Verification
The assertions check, on every cycle, the rules that depend only on port behaviour:
- what follows a key write and a non-key write;
- that the error flag stays set until a key write;
- that reads while unlocked or after the sequence has finished return zero;
- that done implies locked.

Only the bench scenarios can show the register order, the per-register masks and the status bits that survive a restore. They also show that writes made before a restart stay committed. The bench checks these by comparing a save stream against a behavioural model after a restore and after status changes.

// File: rtl/dsr_pkg.sv
package dsr_pkg;
  localparam int unsigned DSR_NREG = 22;
  localparam logic [31:0] DSR_KEY  = 32'hC5AC_CE55;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_LEN, SQ_PICK, SQ_SAVE, SQ_RESTORE, SQ_DONE
  } sq_state_e;

  // Bits software may write, by sequence index
  function automatic logic [31:0] dsr_wmask(int unsigned idx);
    logic [31:0] m;
    if (idx <= 1)       m = 32'h1F1F_FFFF;
    else if (idx <= 3)  m = 32'hFFFF_FFFC;
    else if (idx <= 9)  m = 32'h0077_FFFF;
    else if (idx <= 15) m = 32'hFFFF_FFFC;
    else if (idx == 16) m = 32'hFFFF_FFFF;
    else if (idx == 17) m = 32'h0060_C0FC;
    else if (idx == 18) m = 32'hFFFF_FFFF;
    else if (idx == 19) m = 32'h0000_0007;
    else if (idx == 20) m = 32'h0000_00DF;
    else                m = 32'hFFFF_FFFE;
    return m;
  endfunction

  // Status bits that a restore may still load
  function automatic logic [31:0] dsr_smask(int unsigned idx);
    return (idx == 17) ? 32'h6C00_0000 : 32'h0;
  endfunction

  function automatic logic [31:0] dsr_rstval(int unsigned idx);
    return (idx == 17) ? 32'h0000_0002 : 32'h0;
  endfunction

  function automatic logic [DSR_NREG-1:0][31:0] dsr_wmask_all();
    logic [DSR_NREG-1:0][31:0] a;
    for (int unsigned i = 0; i < DSR_NREG; i++) a[i] = dsr_wmask(i);
    return a;
  endfunction

  function automatic logic [DSR_NREG-1:0][31:0] dsr_smask_all();
    logic [DSR_NREG-1:0][31:0] a;
    for (int unsigned i = 0; i < DSR_NREG; i++) a[i] = dsr_smask(i);
    return a;
  endfunction

  function automatic logic [DSR_NREG-1:0][31:0] dsr_rstval_all();
    logic [DSR_NREG-1:0][31:0] a;
    for (int unsigned i = 0; i < DSR_NREG; i++) a[i] = dsr_rstval(i);
    return a;
  endfunction
endpackage

// File: rtl/dsr_seq_ctrl.sv
module dsr_seq_ctrl
  import dsr_pkg::*;
#(
  parameter int unsigned NREG = DSR_NREG,
  parameter int unsigned PW   = $clog2(NREG + 1),
  parameter logic [31:0] KEY  = DSR_KEY
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          lock_wr,
  input  logic [31:0]   lock_wdata,
  input  logic          port_rd,
  input  logic          port_wr,
  output logic          locked,
  output logic          seq_err,
  output logic          seq_done,
  output logic          len_rd,
  output logic          xfer_rd,
  output logic          xfer_wr,
  output logic [PW-1:0] ptr
);
  sq_state_e     st_q, st_d;
  logic [PW-1:0] ptr_q, ptr_d;
  logic          err_q, err_d;
  logic          upd_en;
  logic          key_wr, unlock_wr, rd_only, wr_only, bad_acc, last_x;

  always_comb begin
    key_wr    = lock_wr && (lock_wdata == KEY);
    unlock_wr = lock_wr && (lock_wdata != KEY);
    rd_only   = port_rd && !port_wr;
    wr_only   = port_wr && !port_rd;
    len_rd    = (st_q == SQ_LEN) && rd_only;
    xfer_rd   = ((st_q == SQ_PICK) || (st_q == SQ_SAVE)) && rd_only;
    xfer_wr   = ((st_q == SQ_PICK) || (st_q == SQ_RESTORE)) && wr_only;
    bad_acc   = (port_rd || port_wr) && !(len_rd || xfer_rd || xfer_wr);
    last_x    = (ptr_q == PW'(NREG - 1));
    upd_en    = lock_wr || port_rd || port_wr;
  end

  always_comb begin
    st_d  = st_q;
    ptr_d = ptr_q;
    err_d = err_q;
    if (key_wr) begin
      st_d  = SQ_LEN;
      ptr_d = '0;
      err_d = 1'b0;
    end else if (unlock_wr) begin
      st_d  = SQ_IDLE;
      ptr_d = '0;
    end else begin
      if (len_rd) st_d = SQ_PICK;
      if (xfer_rd || xfer_wr) begin
        ptr_d = ptr_q + PW'(1);
        if (last_x)       st_d = SQ_DONE;
        else if (xfer_rd) st_d = SQ_SAVE;
        else              st_d = SQ_RESTORE;
      end
      if (bad_acc) err_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= SQ_IDLE;
      ptr_q <= '0;
      err_q <= 1'b0;
    end else if (upd_en) begin
      st_q  <= st_d;
      ptr_q <= ptr_d;
      err_q <= err_d;
    end
  end

  assign locked   = (st_q != SQ_IDLE);
  assign seq_err  = err_q;
  assign seq_done = (st_q == SQ_DONE);
  assign ptr      = ptr_q;
endmodule

// File: rtl/dsr_regfile.sv
module dsr_regfile
  import dsr_pkg::*;
#(
  parameter int unsigned NREG = DSR_NREG,
  parameter int unsigned PW   = $clog2(NREG + 1),
  parameter logic [NREG-1:0][31:0] WMASK  = dsr_wmask_all(),
  parameter logic [NREG-1:0][31:0] SMASK  = dsr_smask_all(),
  parameter logic [NREG-1:0][31:0] RSTVAL = dsr_rstval_all()
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [PW-1:0] idx,
  input  logic [31:0]   wdata,
  input  logic          stat_we,
  input  logic [PW-1:0] stat_idx,
  input  logic [31:0]   stat_data,
  output logic [31:0]   rd_data
);
  logic [31:0] q [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    localparam logic [31:0] RMASK = WMASK[g] | SMASK[g];
    logic        hit_w, hit_s, en;
    logic [31:0] nxt;

    always_comb begin
      hit_w = wr_en && (idx == PW'(g));
      hit_s = stat_we && (stat_idx == PW'(g));
      en    = hit_w || hit_s;
      nxt   = q[g];
      if (hit_s) nxt = (nxt & WMASK[g]) | (stat_data & ~WMASK[g]);
      if (hit_w) nxt = (nxt & ~RMASK) | (wdata & RMASK);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q[g] <= RSTVAL[g];
      else if (en) q[g] <= nxt;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < NREG; i++)
      if (idx == PW'(i)) rd_data = q[i];
  end
endmodule

// File: rtl/dsr_save_restore.sv
module dsr_save_restore
  import dsr_pkg::*;
#(
  parameter int unsigned NREG = DSR_NREG,
  parameter logic [31:0] KEY  = DSR_KEY,
  parameter logic [NREG-1:0][31:0] WMASK  = dsr_wmask_all(),
  parameter logic [NREG-1:0][31:0] SMASK  = dsr_smask_all(),
  parameter logic [NREG-1:0][31:0] RSTVAL = dsr_rstval_all(),
  localparam int unsigned PW = $clog2(NREG + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_rd,
  input  logic          bus_wr,
  input  logic [31:0]   bus_wdata,
  output logic [31:0]   bus_rdata,
  input  logic          stat_we,
  input  logic [PW-1:0] stat_idx,
  input  logic [31:0]   stat_data,
  output logic          locked,
  output logic          seq_err,
  output logic          seq_done
);
  logic          lock_wr, port_rd, port_wr;
  logic          len_rd, xfer_rd, xfer_wr;
  logic [PW-1:0] ptr;
  logic [31:0]   rf_rd;

  assign lock_wr = bus_wr && bus_sel;
  assign port_rd = bus_rd && !bus_sel;
  assign port_wr = bus_wr && !bus_sel;

  dsr_seq_ctrl #(.NREG(NREG), .PW(PW), .KEY(KEY)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .lock_wr(lock_wr), .lock_wdata(bus_wdata),
    .port_rd(port_rd), .port_wr(port_wr),
    .locked(locked), .seq_err(seq_err), .seq_done(seq_done),
    .len_rd(len_rd), .xfer_rd(xfer_rd), .xfer_wr(xfer_wr), .ptr(ptr)
  );

  dsr_regfile #(
    .NREG(NREG), .PW(PW), .WMASK(WMASK), .SMASK(SMASK), .RSTVAL(RSTVAL)
  ) u_rf (
    .clk(clk), .rst_n(rst_n),
    .wr_en(xfer_wr), .idx(ptr), .wdata(bus_wdata),
    .stat_we(stat_we), .stat_idx(stat_idx), .stat_data(stat_data),
    .rd_data(rf_rd)
  );

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      if (bus_sel)      bus_rdata = {31'b0, locked};
      else if (len_rd)  bus_rdata = 32'(NREG);
      else if (xfer_rd) bus_rdata = rf_rd;
    end
  end
endmodule

// File: rtl/dsr_save_restore_chk.sv
module dsr_save_restore_chk #(
  parameter logic [31:0] KEY = 32'hC5AC_CE55
) (
  input logic        clk,
  input logic        rst_n,
  input logic        bus_sel,
  input logic        bus_rd,
  input logic        bus_wr,
  input logic [31:0] bus_wdata,
  input logic [31:0] bus_rdata,
  input logic        locked,
  input logic        seq_err,
  input logic        seq_done
);
  AST_KEY_ARMS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_wdata == KEY) |=> (locked && !seq_err && !seq_done)); // R2

  AST_NONKEY_UNLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && bus_wdata != KEY) |=> (!locked && !seq_done)); // R11

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_err && !(bus_sel && bus_wr && bus_wdata == KEY)) |=> seq_err); // R11

  AST_UNLOCKED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && bus_rd && !bus_sel) |-> (bus_rdata == 32'h0)); // R11

  AST_DONE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_done && bus_rd && !bus_sel) |-> (bus_rdata == 32'h0)); // R9

  AST_DONE_IS_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    seq_done |-> locked); // R9

  AST_LOCK_READ_FORMAT: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_rd) |-> (bus_rdata == {31'b0, locked})); // R12
endmodule

bind dsr_save_restore dsr_save_restore_chk #(.KEY(KEY)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rd(bus_rd),
  .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .locked(locked), .seq_err(seq_err), .seq_done(seq_done)
);

// File: tb/dsr_save_restore_tb.sv
module dsr_save_restore_tb;
  localparam int N = 22;
  localparam logic [31:0] KEYV = 32'hC5AC_CE55;

  logic        clk, rst_n;
  logic        bus_sel, bus_rd, bus_wr, stat_we;
  logic [31:0] bus_wdata, bus_rdata, stat_data;
  logic [4:0]  stat_idx;
  logic        locked, seq_err, seq_done;

  int n_chk = 0, n_fail = 0;

  // behavioural reference: 0 idle 1 len 2 pick 3 save 4 restore 5 done
  int          m_mode, m_ptr;
  bit          m_err;
  logic [31:0] m_reg [N];

  dsr_save_restore u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .stat_we(stat_we), .stat_idx(stat_idx), .stat_data(stat_data),
    .locked(locked), .seq_err(seq_err), .seq_done(seq_done)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] wm(int i);
    case (i)
      0, 1:                     return 32'h1F1F_FFFF;
      2, 3, 10, 11, 12, 13, 14, 15: return 32'hFFFF_FFFC;
      4, 5, 6, 7, 8, 9:         return 32'h0077_FFFF;
      16, 18:                   return 32'hFFFF_FFFF;
      17:                       return 32'h0060_C0FC;
      19:                       return 32'h0000_0007;
      20:                       return 32'h0000_00DF;
      default:                  return 32'hFFFF_FFFE;
    endcase
  endfunction

  function automatic logic [31:0] rm(int i);
    return (i == 17) ? 32'h6C60_C0FC : wm(i);
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] m_rdata();
    if (!bus_rd) return 32'h0;
    if (bus_sel) return {31'b0, m_mode != 0};
    if (bus_wr)  return 32'h0;
    if (m_mode == 1) return 32'(N);
    if (m_mode == 2 || m_mode == 3) return m_reg[m_ptr];
    return 32'h0;
  endfunction

  task automatic m_step();
    if (stat_we && stat_idx < N)
      m_reg[stat_idx] = (m_reg[stat_idx] & wm(stat_idx)) | (stat_data & ~wm(stat_idx));
    if (bus_sel && bus_wr) begin
      if (bus_wdata == KEYV) begin m_mode = 1; m_ptr = 0; m_err = 0; end
      else begin m_mode = 0; m_ptr = 0; end
    end else if (!bus_sel && (bus_rd || bus_wr)) begin
      if (m_mode == 1 && bus_rd && !bus_wr) m_mode = 2;
      else if ((m_mode == 2 || m_mode == 3) && bus_rd && !bus_wr) begin
        m_ptr++; m_mode = (m_ptr == N) ? 5 : 3;
      end else if ((m_mode == 2 || m_mode == 4) && bus_wr && !bus_rd) begin
        m_reg[m_ptr] = (m_reg[m_ptr] & ~rm(m_ptr)) | (bus_wdata & rm(m_ptr));
        m_ptr++; m_mode = (m_ptr == N) ? 5 : 4;
      end else m_err = 1;
    end
  endtask

  task automatic cyc(bit s, bit w, bit r, logic [31:0] d, string req,
                     bit sw = 0, int si = 0, logic [31:0] sd = 0);
    @(negedge clk);
    bus_sel = s; bus_wr = w; bus_rd = r; bus_wdata = d;
    stat_we = sw; stat_idx = 5'(si); stat_data = sd;
    #1;
    if (r) chk(req, "rdata", bus_rdata, m_rdata());
    @(posedge clk);
    m_step();
    #1;
    chk(req, "locked", 32'(locked), 32'(m_mode != 0));
    chk(req, "seq_err", 32'(seq_err), 32'(m_err));
    chk(req, "seq_done", 32'(seq_done), 32'(m_mode == 5));
    bus_wr = 0; bus_rd = 0; stat_we = 0;
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    bus_sel = 0; bus_rd = 0; bus_wr = 0; bus_wdata = 0;
    stat_we = 0; stat_idx = 0; stat_data = 0;
    m_mode = 0; m_ptr = 0; m_err = 0;
    for (int i = 0; i < N; i++) m_reg[i] = (i == 17) ? 32'h2 : 32'h0;
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1", "locked after reset", 32'(locked), 0);
    chk("R1", "seq_err after reset", 32'(seq_err), 0);
    chk("R1", "seq_done after reset", 32'(seq_done), 0);
    cyc(1, 0, 1, 0, "R12");
    // save reset values
    cyc(1, 1, 0, KEYV, "R2");
    cyc(1, 0, 1, 0, "R12");
    cyc(0, 0, 1, 0, "R3");
    for (int i = 0; i < N; i++) cyc(0, 0, 1, 0, "R1");
    cyc(0, 0, 1, 0, "R9");
    // restore distinct patterns
    cyc(1, 1, 0, KEYV, "R2");
    cyc(0, 1, 0, 32'h1234_5678, "R8");
    cyc(0, 0, 1, 0, "R8");
    for (int i = 0; i < N; i++) cyc(0, 1, 0, 32'h9E37_79B9 * (i + 1), "R5");
    cyc(0, 1, 0, 32'hFFFF_FFFF, "R9");
    cyc(1, 1, 0, KEYV, "R2");
    cyc(0, 0, 1, 0, "R3");
    for (int i = 0; i < N; i++) cyc(0, 0, 1, 0, "R4");
    // status bits, restore of zeros, then save
    for (int i = 0; i < N; i++) cyc(0, 0, 0, 0, "R6", 1, i, 32'hFFFF_FFFF);
    cyc(1, 1, 0, KEYV, "R6");
    cyc(0, 0, 1, 0, "R6");
    for (int i = 0; i < N; i++) cyc(0, 1, 0, 32'h0, "R6");
    cyc(1, 1, 0, KEYV, "R6");
    cyc(0, 0, 1, 0, "R6");
    for (int i = 0; i < N; i++) cyc(0, 0, 1, 0, "R6");
    // direction lock
    cyc(1, 1, 0, KEYV, "R7");
    cyc(0, 0, 1, 0, "R7");
    cyc(0, 0, 1, 0, "R7");
    cyc(0, 1, 0, 32'hDEAD_BEEF, "R7");
    cyc(0, 1, 1, 32'hDEAD_BEEF, "R7");
    cyc(0, 0, 1, 0, "R7");
    cyc(1, 1, 0, KEYV, "R7");
    cyc(0, 0, 1, 0, "R7");
    cyc(0, 1, 0, 32'h0F0F_0F0F, "R7");
    cyc(0, 0, 1, 0, "R7");
    // restart mid-restore keeps committed writes
    cyc(1, 1, 0, KEYV, "R10");
    cyc(0, 0, 1, 0, "R10");
    for (int i = 0; i < 5; i++) cyc(0, 1, 0, 32'hA5A5_0000 + i, "R10");
    cyc(1, 1, 0, KEYV, "R10");
    cyc(0, 0, 1, 0, "R10");
    for (int i = 0; i < 8; i++) cyc(0, 0, 1, 0, "R10");
    // non-key unlock
    cyc(1, 1, 0, 32'h0, "R11");
    cyc(1, 0, 1, 0, "R11");
    cyc(0, 0, 1, 0, "R11");
    cyc(0, 1, 0, 32'h5555_5555, "R11");
    cyc(1, 1, 0, 32'h1, "R11");
    cyc(0, 0, 0, 0, "R11");
    cyc(1, 1, 0, KEYV, "R11");
    cyc(0, 0, 1, 0, "R3");
    for (int i = 0; i < N; i++) cyc(0, 0, 1, 0, "R4");
    finish_run();
  end
endmodule